// File: doc/BRIEF.md
# Lane-Parallel Vector Rotate-and-Mask Unit

This block applies a rotate-left followed by a bit-range mask to every lane of a 128-bit vector. A width select splits the vector either into four 32-bit lanes or into two 64-bit lanes. Each lane is computed on its own from three operands: a source value, a control value and the previous destination value. The control lane holds three fields: the rotate amount, the first mask position and the last mask position. The mask can wrap around the lane boundary.

Two merge modes are offered. Insert mode keeps the destination's old bits wherever the mask is clear. Clear mode zeroes those bits. An operation is accepted on any clock where `in_valid` is high. Its result appears in a register one clock later, flagged by `out_valid`. The unit sits beside a vector register file. Operand fetch, decoding and exception handling happen outside it.

Top module: `vec_rotmask`

## Requirements
- R1: In each control lane, bits [5:0] are the rotate amount, bits [13:8] are the last mask position and bits [21:16] are the first mask position. Bit 0 is the lane's least significant bit. All other control bits are ignored.
- R2: With 32-bit lanes, only the low 5 bits of each 6-bit field are used. Bit 5 of each field has no effect on the result.
- R3: Mask positions are numbered from the lane's most significant bit, which is position 0. When first <= last, the mask is set at positions first through last, inclusive.
- R4: When first > last, the mask is set at positions 0 through last and at positions first through the lane's final position. It is clear only at positions last+1 through first-1.
- R5: The source lane is rotated left by the rotate amount. Bits leaving the top of the lane re-enter at the bottom.
- R6: With `insert_mode` = 1, each lane result is (rotated AND mask) OR (old destination AND NOT mask).
- R7: With `insert_mode` = 0, each lane result is rotated AND mask. All bits outside the mask are zero.
- R8: With `lane64` = 1, lane k occupies vector bits [64k+63:64k] for k = 0..1. With `lane64` = 0, lane k occupies bits [32k+31:32k] for k = 0..3. No lane's result depends on another lane's operands.
- R9: `out_valid` on a clock equals `in_valid` on the previous clock. `result` updates on that same edge to the value computed from the operands captured with `in_valid`.
- R10: While `in_valid` is low, `result` holds its last value whatever the other inputs do.
- R11: The reset is synchronous and active low. While `rst_n` is sampled low, `out_valid` and `result` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid; capture on this edge |
| lane64 | input | 1 | 1: two 64-bit lanes, 0: four 32-bit lanes |
| insert_mode | input | 1 | 1: keep old destination bits outside mask, 0: zero them |
| src_a | input | 128 | Source vector to rotate |
| ctrl_b | input | 128 | Per-lane control: rotate amount, mask first, mask last |
| old_d | input | 128 | Previous destination vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered rotate-and-mask result |

## Verification
Directed vectors separate the two mask shapes. Non-wrapping ranges (first <= last) and wrapping ranges (first > last) are tried, including single-bit masks and the full-lane mask with first = 0 and last = the final position. Rotate amounts of zero, one and the lane width minus one show whether the rotation wraps correctly. A 32-bit case with bit 5 set in every field shows whether that bit is ignored. Lanes are given different controls in the same vector, so any crosstalk between lanes becomes visible. Long runs of random operands are then sent in both widths and both merge modes, mixed with idle clocks whose inputs change and with a reset in the middle of traffic. The bench's behavioural model is compared with the design on every clock.

// File: rtl/vrm_pkg.sv
// Package: shared constants for the vector rotate-and-mask unit.
// Assumes lanes are a power of two wide and fit the control field width.
package vrm_pkg;
    localparam int VEC_W    = 128;  // vector width
    localparam int FIELD_W  = 6;    // width of each control field
    localparam int ROT_LSB  = 0;    // rotate amount field position
    localparam int LAST_LSB = 8;    // last mask position field
    localparam int FRST_LSB = 16;   // first mask position field

    typedef enum logic {
        MERGE_CLEAR  = 1'b0,
        MERGE_INSERT = 1'b1
    } merge_e;
endpackage

// File: rtl/vrm_rotl.sv
// Module: vrm_rotl - rotates a W-bit value left by amt positions.
// Assumes W is a power of two and amt is log2(W) bits wide.
module vrm_rotl #(
    parameter int W  = 32,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    // Shift a doubled copy so wrapped bits come in from the low half.
    always_comb begin
        doubled = {din, din} << amt;
        dout    = doubled[2*W-1:W];
    end
endmodule

// File: rtl/vrm_mask.sv
// Module: vrm_mask - builds a contiguous or wrapping mask.
// Positions count from the MSB (position 0). If first <= last the
// range first..last is set; otherwise the set bits wrap around the lane.
module vrm_mask #(
    parameter int W  = 32,
    localparam int LW = $clog2(W)
) (
    input  logic [LW-1:0] first,
    input  logic [LW-1:0] last,
    output logic [W-1:0]  mask
);
    logic wraps;

    // Per-bit membership test against the two boundaries.
    always_comb begin
        wraps = (first > last);
        for (int j = 0; j < W; j++) begin
            logic [LW-1:0] pos;
            logic          ge_first;
            logic          le_last;
            pos      = LW'(W - 1 - j);
            ge_first = (pos >= first);
            le_last  = (pos <= last);
            mask[j]  = wraps ? (ge_first | le_last) : (ge_first & le_last);
        end
    end
endmodule

// File: rtl/vrm_lane.sv
// Module: vrm_lane - one lane: rotate, mask, then merge with the old value.
// Assumes the control fields are already cut down to log2(W) bits.
module vrm_lane #(
    parameter int W  = 32,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  old,
    input  logic [LW-1:0] rot_amt,
    input  logic [LW-1:0] first,
    input  logic [LW-1:0] last,
    input  vrm_pkg::merge_e merge,
    output logic [W-1:0]  res
);
    logic [W-1:0] rotated;
    logic [W-1:0] mask;

    vrm_rotl #(.W(W)) rotl_i (.din(src), .amt(rot_amt), .dout(rotated));
    vrm_mask #(.W(W)) mask_i (.first(first), .last(last), .mask(mask));

    // Merge: bits outside the mask come from old value or are zero.
    always_comb begin
        if (merge == vrm_pkg::MERGE_INSERT)
            res = (rotated & mask) | (old & ~mask);
        else
            res = rotated & mask;
    end
endmodule

// File: rtl/vec_rotmask.sv
// Module: vec_rotmask - lane-parallel rotate-and-mask on a 128-bit vector.
// Both lane widths are computed in parallel and a select picks one; the
// result is registered and flagged one clock after in_valid.
module vec_rotmask #(
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         lane64,
    input  logic         insert_mode,
    input  logic [127:0] src_a,
    input  logic [127:0] ctrl_b,
    input  logic [127:0] old_d,
    output logic         out_valid,
    output logic [127:0] result
);
    import vrm_pkg::*;

    localparam int N_NARROW = VEC_W / NARROW_W;
    localparam int N_WIDE   = VEC_W / WIDE_W;
    localparam int NLW      = $clog2(NARROW_W);
    localparam int WLW      = $clog2(WIDE_W);

    merge_e       merge;
    logic [127:0] narrow_res;
    logic [127:0] wide_res;
    logic [127:0] next_res;

    assign merge = insert_mode ? MERGE_INSERT : MERGE_CLEAR;

    genvar k;
    generate
        for (k = 0; k < N_NARROW; k++) begin : g_narrow
            logic [NARROW_W-1:0] ctl;
            assign ctl = ctrl_b[k*NARROW_W +: NARROW_W];
            vrm_lane #(.W(NARROW_W)) lane_i (
                .src     (src_a[k*NARROW_W +: NARROW_W]),
                .old     (old_d[k*NARROW_W +: NARROW_W]),
                .rot_amt (ctl[ROT_LSB  +: NLW]),
                .first   (ctl[FRST_LSB +: NLW]),
                .last    (ctl[LAST_LSB +: NLW]),
                .merge   (merge),
                .res     (narrow_res[k*NARROW_W +: NARROW_W])
            );
        end
        for (k = 0; k < N_WIDE; k++) begin : g_wide
            logic [WIDE_W-1:0] ctl;
            assign ctl = ctrl_b[k*WIDE_W +: WIDE_W];
            vrm_lane #(.W(WIDE_W)) lane_i (
                .src     (src_a[k*WIDE_W +: WIDE_W]),
                .old     (old_d[k*WIDE_W +: WIDE_W]),
                .rot_amt (ctl[ROT_LSB  +: WLW]),
                .first   (ctl[FRST_LSB +: WLW]),
                .last    (ctl[LAST_LSB +: WLW]),
                .merge   (merge),
                .res     (wide_res[k*WIDE_W +: WIDE_W])
            );
        end
    endgenerate

    // Pick the lane arrangement requested for this operation.
    assign next_res = lane64 ? wide_res : narrow_res;

    // Output register with one-cycle valid; result holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end
endmodule

// File: rtl/vrm_checker.sv
// Module: vrm_checker - temporal properties of vec_rotmask, bound to it.
module vrm_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         insert_mode,
    input logic [127:0] src_a,
    input logic [127:0] ctrl_b,
    input logic [127:0] old_d,
    input logic         out_valid,
    input logic [127:0] result
);
    // R11: reset clears the valid flag and the result.
    p_reset_clears_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R9: an accepted operation is flagged one clock later.
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: no valid without an operation one clock earlier.
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: result holds while idle.
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R7: clear mode with a zero source yields zero.
    p_clear_zero_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !insert_mode && src_a == '0) |=> (result == '0));

    // R6: insert with no rotation and source equal to old gives old back.
    p_insert_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insert_mode && ctrl_b == '0 && src_a == old_d)
            |=> (result == $past(old_d)));
endmodule

bind vec_rotmask vrm_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insert_mode (insert_mode),
    .src_a       (src_a),
    .ctrl_b      (ctrl_b),
    .old_d       (old_d),
    .out_valid   (out_valid),
    .result      (result)
);

// File: tb/vec_rotmask_tb_top.sv
`timescale 1ns/1ps
module vec_rotmask_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         lane64 = 1'b0;
    logic         insert_mode = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] ctrl_b = '0;
    logic [127:0] old_d = '0;
    logic         out_valid;
    logic [127:0] result;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    bit checking = 1'b0;

    string        cur_tag = "R11";
    string        exp_tag = "R11";
    logic         exp_valid = 1'b0;
    logic [127:0] exp_result = '0;

    always #2.5 clk = ~clk;

    vec_rotmask dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane64(lane64),
        .insert_mode(insert_mode), .src_a(src_a), .ctrl_b(ctrl_b),
        .old_d(old_d), .out_valid(out_valid), .result(result)
    );

    // Behavioural model of one lane, bit by bit.
    function automatic logic [63:0] ref_lane(input logic [63:0] s,
            input logic [63:0] c, input logic [63:0] o, input bit ins,
            input int w);
        int sh, fst, lst;
        logic [63:0] r;
        sh  = int'(c[5:0])   % w;
        lst = int'(c[13:8])  % w;
        fst = int'(c[21:16]) % w;
        r = '0;
        for (int j = 0; j < w; j++) begin
            int p;
            bit in_m;
            logic rb;
            p  = w - 1 - j;
            rb = s[(j - sh + w) % w];
            if (fst <= lst) in_m = (p >= fst) && (p <= lst);
            else            in_m = (p >= fst) || (p <= lst);
            r[j] = in_m ? rb : (ins ? o[j] : 1'b0);
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_vec(input bit wide, input bit ins,
            input logic [127:0] s, input logic [127:0] c, input logic [127:0] o);
        logic [127:0] r;
        int w;
        w = wide ? 64 : 32;
        r = '0;
        for (int k = 0; k < 128 / w; k++) begin
            logic [63:0] l;
            l = ref_lane(64'(s >> (k*w)), 64'(c >> (k*w)), 64'(o >> (k*w)), ins, w);
            for (int b = 0; b < w; b++) r[k*w + b] = l[b];
        end
        return r;
    endfunction

    // Reference state update at each clock edge.
    always @(posedge clk) begin
        exp_tag <= cur_tag;
        if (!rst_n) begin
            exp_valid  <= 1'b0;
            exp_result <= '0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid)
                exp_result <= ref_vec(lane64, insert_mode, src_a, ctrl_b, old_d);
        end
    end

    // Compare design and model away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            compared++;
            if (out_valid !== exp_valid || result !== exp_result) begin
                mismatched++;
                $display("FAIL %s: actual valid=%0b result=%h expected valid=%0b result=%h",
                         exp_tag, out_valid, result, exp_valid, exp_result);
            end
        end
    end

    function automatic logic [63:0] fld(input int rot, input int lst, input int fst);
        return 64'((fst << 16) | (lst << 8) | rot);
    endfunction

    task automatic op(input bit wide, input bit ins, input logic [127:0] s,
                      input logic [127:0] c, input logic [127:0] o, input string tag);
        @(negedge clk);
        cur_tag = tag; in_valid = 1'b1; lane64 = wide; insert_mode = ins;
        src_a = s; ctrl_b = c; old_d = o;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_tag = tag; in_valid = 1'b0;
            src_a = {4{$urandom}}; ctrl_b = {4{$urandom}}; old_d = {4{$urandom}};
            insert_mode = $urandom; lane64 = $urandom;
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        // R11: reset state observed while reset is held.
        repeat (3) @(negedge clk);
        checking = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R5 R1: 64-bit rotate by 4, full-lane mask.
        op(1, 0, {64'h8000_0000_0000_0001, 64'h1}, {fld(1, 63, 0), fld(4, 63, 0)}, '0, "R5");
        // R5: rotate by width-1 and by zero.
        op(1, 0, {64'h0123_4567_89AB_CDEF, 64'hF000_0000_0000_000F},
           {fld(0, 63, 0), fld(63, 63, 0)}, '0, "R5");
        // R3: non-wrapping ranges, single bit and mid range.
        op(1, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {fld(0, 15, 8), fld(0, 7, 7)}, '0, "R3");
        // R4: wrapping ranges in insert mode.
        op(1, 1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {fld(0, 3, 60), fld(5, 0, 63)},
           {2{64'h0}}, "R4");
        // R6: insert keeps old bits outside the mask.
        op(0, 1, {4{32'h0000_00FF}}, {fld(8, 23, 16), fld(4, 31, 28)},
           {4{32'hA5A5_A5A5}}, "R6");
        // R7: clear zeroes outside bits.
        op(0, 0, {4{32'hFFFF_FFFF}}, {fld(3, 10, 2), fld(0, 2, 29)},
           {4{32'hFFFF_FFFF}}, "R7");
        // R2: bit 5 of each field ignored for 32-bit lanes.
        op(0, 1, {4{32'h1234_5678}}, {4{32'(fld(33, 36, 40))}}, {4{32'h0F0F_0F0F}}, "R2");
        // R1: junk in unused control bits has no effect.
        op(1, 0, {2{64'hDEAD_BEEF_0BAD_F00D}},
           {64'hFFFF_FFFF_FFC0_C0C0 | fld(9, 40, 20), 64'hAAAA_AAAA_AAC0_C0C0 | fld(17, 50, 2)},
           '0, "R1");
        // R8: different controls per 32-bit lane.
        op(0, 0, {4{32'hCAFE_F00D}}, {32'(fld(1, 31, 0)), 32'(fld(2, 15, 0)),
           32'(fld(3, 31, 16)), 32'(fld(0, 4, 28))}, '0, "R8");
        // R10: idle clocks with changing inputs.
        idle(5, "R10");
        // R9: back-to-back operations.
        for (int i = 0; i < 6; i++) op(i[0], i[1], rnd128(), rnd128(), rnd128(), "R9");
        idle(2, "R9");
        // R6 R7: random traffic in every width/mode with idle gaps.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1, "R10");
            else op($urandom, $urandom, rnd128(), rnd128(), rnd128(),
                    ($urandom % 2) ? "R6" : "R7");
        end
        // R11: reset in the middle of traffic.
        op(1, 1, rnd128(), rnd128(), rnd128(), "R11");
        @(negedge clk); rst_n = 1'b0; cur_tag = "R11";
        repeat (2) @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        op(0, 0, rnd128(), rnd128(), rnd128(), "R9");
        idle(3, "R10");
        @(negedge clk);
        checking = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #900000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule